// File: doc/BRIEF.md
# Instruction Fetch Address Translator

The block turns the address of an instruction fetch into a physical address and decides whether the fetch may go ahead. Three routes can produce the address. A fetch address with bit 0 set belongs to privileged code: that bit is cleared and the rest is used as-is. A request flagged as physical uses its virtual address unchanged. Every other fetch takes the physical page number from a translation lookup result supplied alongside the request.

Once the address is formed, two checks run. The first looks for bits set outside the implemented physical range. The second marks addresses in the uncacheable I/O window. An instruction fetch is not allowed to read from that window, because reading a device register can clear state held in it. Such a fetch is reported as a fault.

The decision is made in one combinational pass. The result is registered, so it appears one cycle after the request strobe. Storing and refilling translations is done elsewhere, and so are access-permission checks.

Top module: `ift_translator`

## Requirements
- R1: While reset (`rst_n` low) is held at a clock edge, all outputs read zero after that edge, and `rsp_valid` stays low until a request is accepted.
- R2: `rsp_valid` is high in the cycle after each cycle in which `req_valid` was high at the clock edge, and low after each edge where `req_valid` was low.
- R3: A fetch address with bit 0 set returns `rsp_pa` equal to bits 43:0 of the address with bit 0 cleared, fault code 0 and `rsp_uncached` 0. This holds even when bits 47:44, 39 or 40 are set.
- R4: `rsp_phys` is 1 for a physical-mode request with address bit 0 clear, and for a privileged fetch (bit 0 set) while `full_sys` is 1. It is 0 for a privileged fetch while `full_sys` is 0, and for every lookup-based request.
- R5: A physical-mode request with bit 0 clear uses the 48-bit fetch address itself as the physical address before the range and cacheability checks are applied.
- R6: A lookup-based request with `tlb_hit` set forms the address as {`tlb_ppn`, fetch address bits 12:0}.
- R7: A lookup-based request with `tlb_hit` clear returns fault code 3 (miss), with `rsp_pa` 0 and `rsp_uncached` 0.
- R8: If the formed address has any bit set outside the implemented mask (by default, any of bits 47:44), the result is fault code 1 (machine check), with `rsp_uncached` 0 and `rsp_pa` equal to bits 43:0 of the formed address.
- R9: If the formed address is in range and has bit 39 or bit 40 set, the result is `rsp_uncached` 1, fault code 2 (uncached fetch), and `rsp_pa` equal to the address with bits 42:35 cleared. Otherwise the fault code is 0.
- R10: When an address is both out of range and in the uncacheable window, the machine check (code 1) takes priority.
- R11: `tlb_hit` and `tlb_ppn` have no effect on the result of a physical-mode or privileged request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per fetch |
| fetch_va | input | 48 | Fetch address; bit 0 marks privileged code |
| phys_mode | input | 1 | Treat the request as physical |
| full_sys | input | 1 | Full-system mode enable |
| tlb_hit | input | 1 | Lookup result: a translation was found |
| tlb_ppn | input | 35 | Lookup result: physical page number |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_pa | output | 44 | Physical address |
| rsp_uncached | output | 1 | Address lies in the uncacheable window |
| rsp_fault | output | 2 | 0 none, 1 machine check, 2 uncached fetch, 3 miss |
| rsp_phys | output | 1 | Request was handled without the lookup |

## Verification
The assertions assume the request inputs are known, 2-state values whenever `req_valid` is high. They also assume `tlb_ppn` matters only while `tlb_hit` is set. Results are compared against the inputs sampled at the strobe edge, so the assertions do not depend on those inputs staying stable afterwards. The stimulus changes inputs only on the falling edge and never leaves them undriven. Its random addresses set bits 47:44 and the window bits 39 and 40 often enough to reach every fault route, including the case where out-of-range and uncacheable overlap.

// File: rtl/ift_pkg.sv
// Shared types for the instruction fetch translator.
// Assumes: fault code values are seen by the consumer of rsp_fault.
package ift_pkg;

    // Fault codes reported with every result
    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_MCHK      = 2'd1,
        FLT_UNC_FETCH = 2'd2,
        FLT_MISS      = 2'd3
    } ift_fault_e;

    // Route that produced the raw address
    typedef enum logic [1:0] {
        SRC_PRIV = 2'd0,
        SRC_PHYS = 2'd1,
        SRC_TLB  = 2'd2
    } ift_src_e;

endpackage

// File: rtl/ift_select.sv
// Chooses the route for a fetch and forms the raw (unchecked) address.
// Privileged fetches are marked by bit 0; physical mode passes the
// address through; otherwise the lookup page number is spliced in.
// Assumes: PPN_W + PAGE_BITS == VA_W.
module ift_select
    import ift_pkg::*;
#(
    parameter int VA_W      = 48,
    parameter int PAGE_BITS = 13,
    parameter int PPN_W     = VA_W - PAGE_BITS
) (
    input  logic [VA_W-1:0]  fetch_va,
    input  logic             phys_mode,
    input  logic             full_sys,
    input  logic             tlb_hit,
    input  logic [PPN_W-1:0] tlb_ppn,
    output logic [VA_W-1:0]  raw_addr,
    output ift_src_e         src,
    output logic             miss,
    output logic             phys_used
);

    logic priv_pc;
    assign priv_pc = fetch_va[0];

    // Route selection and raw address formation
    always_comb begin
        raw_addr  = '0;
        src       = SRC_TLB;
        miss      = 1'b0;
        phys_used = 1'b0;
        if (priv_pc) begin
            raw_addr  = {fetch_va[VA_W-1:1], 1'b0};
            src       = SRC_PRIV;
            phys_used = full_sys;
        end else if (phys_mode) begin
            raw_addr  = fetch_va;
            src       = SRC_PHYS;
            phys_used = 1'b1;
        end else begin
            src  = SRC_TLB;
            miss = !tlb_hit;
            if (tlb_hit) begin
                raw_addr = {tlb_ppn, fetch_va[PAGE_BITS-1:0]};
            end
        end
    end

endmodule

// File: rtl/ift_check.sv
// Applies the implemented-range and cacheability checks to a raw
// address and picks the fault code (machine check before uncached
// fetch). Privileged fetches skip both checks.
// Assumes: UNC_HI, UNC_LO, CLR_HI, CLR_LO all lie below PA_W.
module ift_check
    import ift_pkg::*;
#(
    parameter int              VA_W      = 48,
    parameter int              PA_W      = 44,
    parameter logic [VA_W-1:0] IMPL_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}},
    parameter int              UNC_LO    = 39,
    parameter int              UNC_HI    = 40,
    parameter int              CLR_LO    = 35,
    parameter int              CLR_HI    = 42
) (
    input  logic [VA_W-1:0] raw_addr,
    input  ift_src_e        src,
    input  logic            miss,
    output logic [PA_W-1:0] pa,
    output logic            uncached,
    output ift_fault_e      fault
);

    logic [PA_W-1:0] clr_mask;
    logic            out_of_range;
    logic            in_unc_window;

    // Build the mask of bits cleared on an uncacheable address
    always_comb begin
        for (int i = 0; i < PA_W; i++) begin
            clr_mask[i] = (i >= CLR_LO) && (i <= CLR_HI);
        end
    end

    // Range and window detection
    assign out_of_range  = |(raw_addr & ~IMPL_MASK);
    assign in_unc_window = raw_addr[UNC_LO] | raw_addr[UNC_HI];

    // Fault priority and final address
    always_comb begin
        pa       = raw_addr[PA_W-1:0];
        uncached = 1'b0;
        fault    = FLT_NONE;
        if (src == SRC_PRIV) begin
            fault = FLT_NONE;
        end else if (miss) begin
            pa    = '0;
            fault = FLT_MISS;
        end else if (out_of_range) begin
            fault = FLT_MCHK;
        end else if (in_unc_window) begin
            uncached = 1'b1;
            pa       = raw_addr[PA_W-1:0] & ~clr_mask;
            fault    = FLT_UNC_FETCH;
        end
    end

endmodule

// File: rtl/ift_translator.sv
// Top of the fetch translator: combinational route select and checks,
// then one register stage. Results are valid one cycle after req_valid.
// Assumes: request inputs are 2-state while req_valid is high.
module ift_translator
    import ift_pkg::*;
#(
    parameter int VA_W      = 48,
    parameter int PA_W      = 44,
    parameter int PAGE_BITS = 13,
    parameter int PPN_W     = VA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  fetch_va,
    input  logic             phys_mode,
    input  logic             full_sys,
    input  logic             tlb_hit,
    input  logic [PPN_W-1:0] tlb_ppn,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_uncached,
    output logic [1:0]       rsp_fault,
    output logic             rsp_phys
);

    localparam logic [VA_W-1:0] IMPL_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};

    logic [VA_W-1:0] raw_addr;
    ift_src_e        src;
    logic            miss;
    logic            phys_used;
    logic [PA_W-1:0] pa_c;
    logic            unc_c;
    ift_fault_e      fault_c;

    ift_select #(
        .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PPN_W(PPN_W)
    ) u_select (
        .fetch_va (fetch_va),
        .phys_mode(phys_mode),
        .full_sys (full_sys),
        .tlb_hit  (tlb_hit),
        .tlb_ppn  (tlb_ppn),
        .raw_addr (raw_addr),
        .src      (src),
        .miss     (miss),
        .phys_used(phys_used)
    );

    ift_check #(
        .VA_W(VA_W), .PA_W(PA_W), .IMPL_MASK(IMPL_MASK)
    ) u_check (
        .raw_addr(raw_addr),
        .src     (src),
        .miss    (miss),
        .pa      (pa_c),
        .uncached(unc_c),
        .fault   (fault_c)
    );

    // Result register, loaded on each request strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            rsp_fault    <= FLT_NONE;
            rsp_phys     <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa       <= pa_c;
                rsp_uncached <= unc_c;
                rsp_fault    <= fault_c;
                rsp_phys     <= phys_used;
            end
        end
    end

    // R2
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R3
    priv_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fetch_va[0]) |=>
            (rsp_fault == FLT_NONE) && !rsp_uncached && !rsp_pa[0]);
    // R7
    miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fetch_va[0] && !phys_mode && !tlb_hit) |=>
            (rsp_fault == FLT_MISS) && (rsp_pa == '0));
    // R9
    unc_fault_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_UNC_FETCH) |->
            rsp_uncached && (rsp_pa[42:35] == 8'd0));
    // R5
    phys_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fetch_va[0] && phys_mode && fetch_va[VA_W-1:PA_W] == '0
         && !fetch_va[39] && !fetch_va[40]) |=>
            (rsp_pa == $past(fetch_va[PA_W-1:0])) && (rsp_fault == FLT_NONE));
    // R10
    mchk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fetch_va[0] && phys_mode && fetch_va[VA_W-1:PA_W] != '0) |=>
            (rsp_fault == FLT_MCHK) && !rsp_uncached);

endmodule

// File: tb/tb_ift_translator.sv
`timescale 1ns/1ps
module tb_ift_translator;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [47:0] fetch_va;
    logic        phys_mode, full_sys, tlb_hit;
    logic [34:0] tlb_ppn;
    logic        rsp_valid, rsp_uncached, rsp_phys;
    logic [43:0] rsp_pa;
    logic [1:0]  rsp_fault;

    int n_checks = 0;
    int n_fails  = 0;

    // expected values from the behavioural model
    logic [43:0] e_pa;
    logic        e_unc, e_phys;
    logic [1:0]  e_flt;
    string       e_tag;

    always #10 clk = ~clk;

    ift_translator dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fetch_va(fetch_va),
        .phys_mode(phys_mode), .full_sys(full_sys), .tlb_hit(tlb_hit),
        .tlb_ppn(tlb_ppn), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault), .rsp_phys(rsp_phys)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference written from the requirements
    task automatic model(input logic [47:0] va, input logic ph, input logic fs,
                         input logic hit, input logic [34:0] ppn);
        logic [47:0] a;
        e_unc = 1'b0; e_flt = 2'd0; e_phys = 1'b0;
        if (va[0]) begin
            a = va; a[0] = 1'b0;
            e_pa = a[43:0]; e_phys = fs; e_tag = "R3";
            return;
        end
        if (ph) begin
            a = va; e_phys = 1'b1; e_tag = "R5";
        end else begin
            if (!hit) begin
                e_pa = '0; e_flt = 2'd3; e_tag = "R7";
                return;
            end
            a = {ppn, va[12:0]}; e_tag = "R6";
        end
        e_pa = a[43:0];
        if (a[47:44] != 4'd0) begin
            e_flt = 2'd1;
            e_tag = (a[39] | a[40]) ? "R10" : "R8";
        end else if (a[39] | a[40]) begin
            e_unc = 1'b1; e_flt = 2'd2; e_tag = "R9";
            for (int i = 35; i <= 42; i++) e_pa[i] = 1'b0;
        end
    endtask

    // Drive one request at a falling edge, compare after the next rising edge
    task automatic apply(input logic [47:0] va, input logic ph, input logic fs,
                         input logic hit, input logic [34:0] ppn, input string tag);
        req_valid = 1'b1; fetch_va = va; phys_mode = ph; full_sys = fs;
        tlb_hit = hit; tlb_ppn = ppn;
        model(va, ph, fs, hit, ppn);
        if (tag != "") e_tag = tag;
        @(posedge clk); #2;
        chk("R2", "valid", 64'(rsp_valid), 64'd1);
        chk(e_tag, "pa", 64'(rsp_pa), 64'(e_pa));
        chk(e_tag, "uncached", 64'(rsp_uncached), 64'(e_unc));
        chk(e_tag, "fault", 64'(rsp_fault), 64'(e_flt));
        chk("R4", "phys", 64'(rsp_phys), 64'(e_phys));
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0; fetch_va = 48'hFFFF_FFFF_FFFF; tlb_hit = 1'b1;
        @(posedge clk); #2;
        chk("R2", "valid idle", 64'(rsp_valid), 64'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b1; fetch_va = 48'h0000_0000_1000;
        phys_mode = 1'b1; full_sys = 1'b1; tlb_hit = 1'b1; tlb_ppn = '1;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1", "valid", 64'(rsp_valid), 64'd0);
        chk("R1", "pa", 64'(rsp_pa), 64'd0);
        chk("R1", "fault", 64'(rsp_fault), 64'd0);
        chk("R1", "uncached", 64'(rsp_uncached), 64'd0);
        chk("R1", "phys", 64'(rsp_phys), 64'd0);
        @(negedge clk);
        rst_n = 1'b1; req_valid = 1'b0;
        idle();
        // R3 / R4 privileged fetches, junk upper bits, both full_sys settings
        apply(48'hF180_0000_1235, 1'b0, 1'b1, 1'b0, '0, "R3");
        apply(48'h0000_8000_4001, 1'b0, 1'b0, 1'b1, 35'h7_FFFF_FFFF, "R11");
        // R5 physical passthrough, plain and window bits
        apply(48'h0000_1234_5678, 1'b1, 1'b0, 1'b0, '0, "R5");
        apply(48'h0080_0000_2000, 1'b1, 1'b0, 1'b1, 35'h1, "R9");
        apply(48'h0107_F800_0010, 1'b1, 1'b1, 1'b0, '0, "R9");
        // R8 / R10 machine check and priority
        apply(48'h2000_0000_0100, 1'b1, 1'b0, 1'b0, '0, "R8");
        apply(48'h4180_0000_0100, 1'b1, 1'b0, 1'b0, '0, "R10");
        // R6 lookup hit, then hit landing in the window, R7 miss
        apply(48'hAAAA_BBBB_0ABC, 1'b0, 1'b1, 1'b1, 35'h0_0012_3456, "R6");
        apply(48'h0000_0000_1FFE, 1'b0, 1'b0, 1'b1, 35'h0_0400_0000, "R9");
        apply(48'h0000_0000_1000, 1'b0, 1'b1, 1'b0, 35'h0_0000_0042, "R7");
        // R11 physical request with an active lookup result
        apply(48'h0000_0000_C000, 1'b1, 1'b0, 1'b1, 35'h7_FFFF_FFFF, "R11");
        idle();
        // mixed random traffic, with idle gaps
        for (int i = 0; i < 400; i++) begin
            logic [47:0] va;
            logic [34:0] pn;
            va = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            pn = 35'({$urandom, $urandom});
            if ($urandom % 2) va[47:44] = 4'd0;
            if ($urandom % 3 == 0) pn[34:27] = 8'd0;
            if (i % 7 == 0) idle();
            apply(va, 1'($urandom), 1'($urandom), 1'($urandom % 4 != 0), pn, "");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule